// File: doc/BRIEF.md
# Frame Buffer Nibble Streamer

This block feeds a controllerless monochrome flat panel from a byte-wide frame memory. Each request from the panel timing generator makes the block issue one read to the memory, and the returned byte is narrowed to a 4-bit pixel group on the panel data lines. A read pointer walks through one frame's worth of bytes, stops once the frame is fully read, and goes back to the frame base when the timing generator marks the start of a new frame.

A byte holds two independent screens, one per nibble. A screen-select input picks which nibble reaches the panel. The block samples that input only on the frame marker, so every frame shows a single screen. The output nibble is registered and changes only when a read completes. This keeps the data lines steady while the panel strobes them in.

Top module: `nibble_streamer`

## Requirements
- R1: After synchronous reset, `mem_addr` equals the frame base (default 0), `mem_rd` is low, `pix_out` is 4'h0, and the upper-nibble screen is selected.
- R2: A request is accepted when `fetch_req` is high, `frame_mark` is low and the frame is not yet fully read. `mem_rd` is high in exactly that cycle, and only one byte is read per accepted request.
- R3: Each accepted request presents the current pointer on `mem_addr`. The pointer advances by exactly one on the next cycle, so consecutive accepted requests read consecutive addresses.
- R4: On the cycle after `frame_mark` is high, `mem_addr` equals the frame base. A `fetch_req` in the same cycle as `frame_mark` is dropped (`mem_rd` low).
- R5: Once FRAME_BYTES (default 9600) requests have been accepted since the last frame marker or reset, further requests are ignored: `mem_rd` stays low, and `mem_addr` and `pix_out` are unchanged until the next frame marker.
- R6: The screen select is encoded 0 = upper nibble (bits 7:4) and 1 = lower nibble (bits 3:0). It is sampled only in a cycle with `frame_mark` high and has no effect at any other time.
- R7: `pix_out` takes the selected nibble of the byte read for an accepted request on the second rising edge after that request is sampled. It holds its value on every other edge.
- R8: Pixel (x, y) of a 240-pixel-wide frame is held in the byte at offset x/4 + 60*y. Within the active nibble, the leftmost pixel of the group is the nibble's top bit and appears on `pix_out[3]`, so pixel x sits on `pix_out[3 - x%4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_mark | input | 1 | Frame start pulse from the timing generator |
| fetch_req | input | 1 | One pixel-group fetch request per cycle high |
| screen_sel | input | 1 | Screen choice, sampled at frame_mark (0 upper, 1 lower nibble) |
| mem_addr | output | ADDR_W | Frame memory read address |
| mem_rd | output | 1 | Frame memory read enable |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| pix_out | output | 4 | Registered pixel nibble to the panel data lines |

## Verification
The bench reads a full frame and then keeps requesting. A design with an off-by-one end count would read byte 9600 or stop at 9599, and one without the stop would run past the frame. It toggles the screen select in the middle of a frame, where a design that samples continuously would mix the two screens. It also raises a request together with the frame marker, where a faulty design would issue a stray read or skip the base address. Back-to-back requests and a targeted pixel position expose a wrong capture latency, a swapped nibble or reversed bit order as mismatches in the scoreboard.

// File: rtl/nibble_streamer_pkg.sv
package nibble_streamer_pkg;
  typedef enum logic {
    SCREEN_UPPER = 1'b0,
    SCREEN_LOWER = 1'b1
  } screen_e;

  function automatic logic [3:0] pick_nibble(input logic [7:0] b, input screen_e s);
    return (s == SCREEN_LOWER) ? b[3:0] : b[7:4];
  endfunction
endpackage

// File: rtl/ns_addr_seq.sv
module ns_addr_seq #(
  parameter int ADDR_W      = 14,
  parameter int FRAME_BYTES = 9600,
  parameter int BASE_ADDR   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_mark,
  input  logic              fetch_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_en
);
  localparam int CNT_W = $clog2(FRAME_BYTES + 1);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(FRAME_BYTES);

  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              frame_done;

  assign frame_done = (cnt_q == LAST);
  assign rd_en      = fetch_req & ~frame_mark & ~frame_done;
  assign rd_addr    = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= BASE;
      cnt_q <= '0;
    end else if (frame_mark) begin
      ptr_q <= BASE;
      cnt_q <= '0;
    end else if (rd_en) begin
      ptr_q <= ptr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
      cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_addr == $past(rd_addr) + {{(ADDR_W-1){1'b0}}, 1'b1});

  // R4
  addr_rewind_chk: assert property (@(posedge clk) disable iff (rst)
    frame_mark |=> rd_addr == BASE);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !frame_mark) |=> $stable(rd_addr));
endmodule

// File: rtl/ns_capture.sv
module ns_capture
  import nibble_streamer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_mark,
  input  logic       screen_sel,
  input  logic       rd_en,
  input  logic [7:0] rd_data,
  output logic [3:0] pix
);
  screen_e    sel_q;
  logic       pend_q;
  logic [3:0] pix_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SCREEN_UPPER;
    end else if (frame_mark) begin
      sel_q <= screen_e'(screen_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      pix_q  <= 4'h0;
    end else begin
      pend_q <= rd_en;
      if (pend_q) pix_q <= pick_nibble(rd_data, sel_q);
    end
  end

  assign pix = pix_q;

  // R6
  sel_frame_only_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_mark |=> $stable(sel_q));

  // R7
  pix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_q |=> $stable(pix_q));
endmodule

// File: rtl/nibble_streamer.sv
module nibble_streamer #(
  parameter int ADDR_W      = 14,
  parameter int FRAME_BYTES = 9600,
  parameter int BASE_ADDR   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_mark,
  input  logic              fetch_req,
  input  logic              screen_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic [3:0]        pix_out
);
  logic              rd_en_w;
  logic [ADDR_W-1:0] rd_addr_w;

  ns_addr_seq #(
    .ADDR_W     (ADDR_W),
    .FRAME_BYTES(FRAME_BYTES),
    .BASE_ADDR  (BASE_ADDR)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .frame_mark(frame_mark),
    .fetch_req (fetch_req),
    .rd_addr   (rd_addr_w),
    .rd_en     (rd_en_w)
  );

  ns_capture u_cap (
    .clk       (clk),
    .rst       (rst),
    .frame_mark(frame_mark),
    .screen_sel(screen_sel),
    .rd_en     (rd_en_w),
    .rd_data   (mem_rdata),
    .pix       (pix_out)
  );

  assign mem_addr = rd_addr_w;
  assign mem_rd   = rd_en_w;

  // R2
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> fetch_req);
endmodule

// File: tb/nibble_streamer_bench.sv
module nibble_streamer_bench;
  localparam int ADDR_W = 14;
  localparam int FRAME  = 9600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_mark = 1'b0;
  logic fetch_req = 1'b0;
  logic screen_sel = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_rd;
  logic [7:0] mem_rdata = 8'h00;
  logic [3:0] pix_out;

  always #2.5 clk = ~clk;

  nibble_streamer u_nibble_streamer (
    .clk(clk), .rst(rst), .frame_mark(frame_mark), .fetch_req(fetch_req),
    .screen_sel(screen_sel), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .pix_out(pix_out)
  );

  function automatic logic [7:0] byte_at(input int a);
    return 8'((a * 37) + (a >> 6) + 8'h5A);
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) if (mem_rd) mem_rdata <= byte_at(int'(mem_addr));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int         due;
    logic [3:0] nib;
    bit         pchk;
    int         pidx;
    logic       pbit;
  } exp_t;
  exp_t q[$];

  int exp_addr = 0;
  int exp_cnt  = 0;
  logic exp_sel = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected nibbles when due
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      check(pix_out == e.nib, "R7 nibble/latency", pix_out, e.nib);
      if (e.pchk) check(pix_out[e.pidx] == e.pbit, "R8 pixel position", pix_out[e.pidx], e.pbit);
    end
  end

  // called right after a negedge; holds fetch_req for one cycle
  task automatic fetch_one();
    fetch_req = 1'b1;
    #1;
    if (exp_cnt < FRAME) begin
      exp_t e;
      logic [7:0] b;
      b = byte_at(exp_addr);
      check(mem_rd == 1'b1, "R2 read issued", mem_rd, 1);
      check(int'(mem_addr) == exp_addr, "R3 address", mem_addr, exp_addr);
      e.due  = cyc + 2;
      e.nib  = exp_sel ? b[3:0] : b[7:4];
      e.pchk = 1'b0;
      e.pidx = 0;
      e.pbit = 1'b0;
      // pixel x=9, y=2 -> offset 2 + 120 = 122, column 1 in group
      if (exp_addr == 122) begin
        e.pchk = 1'b1;
        e.pidx = 3 - 1;
        e.pbit = exp_sel ? b[3 - 1] : b[7 - 1];
      end
      q.push_back(e);
      exp_addr++;
      exp_cnt++;
    end else begin
      check(mem_rd == 1'b0, "R5 read suppressed", mem_rd, 0);
      check(int'(mem_addr) == exp_addr, "R5 address held", mem_addr, exp_addr);
    end
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic mark(input logic s, input logic with_fetch);
    frame_mark = 1'b1;
    screen_sel = s;
    fetch_req  = with_fetch;
    #1;
    check(mem_rd == 1'b0, "R4 fetch with marker dropped", mem_rd, 0);
    @(negedge clk);
    frame_mark = 1'b0;
    fetch_req  = 1'b0;
    exp_addr = 0;
    exp_cnt  = 0;
    exp_sel  = s;
    check(int'(mem_addr) == 0, "R4 rewind to base", mem_addr, 0);
  endtask

  initial begin
    #750000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] held;
    idle(4);
    rst = 1'b0;
    #1;
    check(int'(mem_addr) == 0, "R1 reset address", mem_addr, 0);
    check(mem_rd == 1'b0, "R1 reset read", mem_rd, 0);
    check(pix_out == 4'h0, "R1 reset pixel", pix_out, 0);
    @(negedge clk);

    // upper screen from reset, spaced requests
    for (int i = 0; i < 20; i++) begin fetch_one(); idle(1); end
    // idle cycles keep the output
    idle(3);
    held = pix_out;
    idle(4);
    check(pix_out == held, "R7 hold while idle", pix_out, held);

    // screen select changed mid-frame has no effect
    screen_sel = 1'b1;
    for (int i = 0; i < 10; i++) fetch_one();
    idle(3);

    // marker selects lower screen, concurrent fetch dropped
    mark(1'b1, 1'b1);
    for (int i = 0; i < 130; i++) fetch_one();
    screen_sel = 1'b0;
    idle(3);

    // full frame, upper screen, back-to-back
    mark(1'b0, 1'b0);
    screen_sel = 1'b1;
    for (int i = 0; i < FRAME; i++) fetch_one();
    idle(3);
    held = pix_out;
    for (int i = 0; i < 6; i++) fetch_one();
    idle(3);
    check(pix_out == held, "R5 pixel unchanged after frame end", pix_out, held);
    check(q.size() == 0, "R5 no extra reads", q.size(), 0);

    // rewind resumes reading
    mark(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) fetch_one();
    idle(4);
    check(q.size() == 0, "R7 scoreboard drained", q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule